// File: doc/BRIEF.md
# Double-Buffered Input Gamma Lookup

This stage sits at the front of an RGB pixel pipeline and maps each colour channel through a programmable curve. It keeps two tables, bank A and bank B. Each bank holds 256 twelve-bit entries for red, green and blue, and each entry is an unsigned fraction with 12 fractional bits. Pixels enter on a valid/ready stream. Only the top 8 bits of each channel form the table index, and each channel is looked up on its own.

A host loads the bank that is not live through plain control pins. It first sets a write index. It then pushes values through one sequential data port, which cycles red, green, blue at each index and then moves to the next index. A three-bit mask decides which channels are stored. The host then requests the new bank through the lookup-mode pins. The pixel path adopts the request only on a frame-start strobe, so one frame never mixes two tables. A status code reports which bank is live.

Back-pressure follows the usual valid/ready rules. A pixel transfers at a clock edge where `pix_in_valid` and `pix_in_ready` are both high. `pix_in_ready` is low only while the output holds a pixel the consumer has not taken. While `pix_out_valid` is high and `pix_out_ready` is low, the output pixel stays unchanged.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset `pix_out_valid` is 0, `lut_status` is 0, `pix_in_ready` is 1, and the pixel path is in bypass.
- R2: `lut_status` reads 1 while bank A is live, 2 while bank B is live and 0 in bypass. It changes only at a clock edge where `frame_start` is high.
- R3: Successive data-port writes at one index go to red, then green, then blue, and the index then advances by one. Index 255 wraps to 0.
- R4: A write to the index (`wr_idx_load`) loads the index and restarts the channel sequence at red. If it coincides with a data write, the data write is dropped and does not advance the sequence.
- R5: `wr_mask` bit 0 enables storage for red, bit 1 for green and bit 2 for blue. A masked write stores nothing but still advances the sequence.
- R6: `wr_bank` sampled with each data write picks the target bank: 0 selects bank A and 1 selects bank B.
- R7: With the live lookup mode at 2, each channel output is bank A's entry for that channel at the channel's index. With the live mode at 3, bank B is used instead.
- R8: With any other live mode, each output is the 8-bit index followed by four zero bits.
- R9: The table index of a channel is the 8 most significant bits of its `IN_W`-bit input. Lower bits are ignored.
- R10: `lut_mode` becomes live at a clock edge where `frame_start` is high. A pixel accepted at that same edge already uses the new mode, and pixels accepted earlier use the old one.
- R11: When the output is not stalled, a pixel accepted at the end of cycle n is on the output, with `pix_out_valid` high, in cycle n+2. In cycle n+1, `pix_out_valid` is low unless an earlier pixel occupies it.
- R12: `pix_in_ready` equals `!pix_out_valid || pix_out_ready`. During a stall the output data stays unchanged, and no pixel is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_idx_load | input | 1 | Load the write index from `wr_idx` |
| wr_idx | input | 8 | Write index value |
| wr_data_valid | input | 1 | Sequential data-port write strobe |
| wr_data | input | 12 | Table entry value (u0.12) |
| wr_bank | input | 1 | Target bank for data writes (0 = A, 1 = B) |
| wr_mask | input | 3 | Channel store enables {blue, green, red} |
| lut_mode | input | 2 | Requested lookup mode (2 = A, 3 = B, other = bypass) |
| frame_start | input | 1 | Frame boundary strobe that makes `lut_mode` live |
| lut_status | output | 3 | Live bank code (1 = A, 2 = B, 0 = none) |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_ready | output | 1 | Input pixel accepted when high with valid |
| pix_in_r | input | IN_W | Input red |
| pix_in_g | input | IN_W | Input green |
| pix_in_b | input | IN_W | Input blue |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_ready | input | 1 | Consumer ready |
| pix_out_r | output | 12 | Output red (u0.12) |
| pix_out_g | output | 12 | Output green (u0.12) |
| pix_out_b | output | 12 | Output blue (u0.12) |

## Verification
The hardest case to reach from the ports is a stall while the pipeline is full. It needs one pixel held at the output, a second pixel in the read stage and a third offered at the input, with none of them lost or duplicated when the stall ends. The stimulus gets there by dropping `pix_out_ready` before two back-to-back pixels. It then presents a third while ready stays low and checks each pixel as the stall releases. The sequence-counter corner cases are written in through the data port: a masked write, a reload of the index in the middle of a triplet, an index load that coincides with a data write, and the wrap from 255 to 0. The results are then read back as pixel lookups.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2
  } chan_e;

  localparam int NUM_CH = 3;

  localparam logic [1:0] MODE_BANK_A = 2'd2;
  localparam logic [1:0] MODE_BANK_B = 2'd3;

  localparam logic [2:0] STAT_NONE = 3'd0;
  localparam logic [2:0] STAT_A    = 3'd1;
  localparam logic [2:0] STAT_B    = 3'd2;

  function automatic logic mode_uses_table(input logic [1:0] m);
    return (m == MODE_BANK_A) || (m == MODE_BANK_B);
  endfunction

  function automatic logic [2:0] status_code(input logic [1:0] m);
    case (m)
      MODE_BANK_A: status_code = STAT_A;
      MODE_BANK_B: status_code = STAT_B;
      default:     status_code = STAT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gamma_lut_writer.sv
module gamma_lut_writer
  import gamma_lut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_load,
  input  logic [IDX_W-1:0] idx_value,
  input  logic             data_valid,
  input  logic [2:0]       mask,
  output logic [2:0]       chan_we,
  output logic [IDX_W-1:0] cur_idx
);

  chan_e            seq_ch;
  logic [IDX_W-1:0] seq_idx;
  logic             data_go;

  assign data_go = data_valid && !idx_load;
  assign cur_idx = seq_idx;

  always_comb begin
    chan_we = 3'b000;
    if (data_go) begin
      case (seq_ch)
        CH_RED:   chan_we[0] = mask[0];
        CH_GREEN: chan_we[1] = mask[1];
        default:  chan_we[2] = mask[2];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_ch  <= CH_RED;
      seq_idx <= '0;
    end else if (idx_load) begin
      seq_ch  <= CH_RED;
      seq_idx <= idx_value;
    end else if (data_go) begin
      case (seq_ch)
        CH_RED:   seq_ch <= CH_GREEN;
        CH_GREEN: seq_ch <= CH_BLUE;
        default: begin
          seq_ch  <= CH_RED;
          seq_idx <= seq_idx + 1'b1;
        end
      endcase
    end
  end

  // R3: blue write closes the triplet, index steps (wrapping)
  assert_triplet_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go && seq_ch == CH_BLUE) |=>
      (seq_ch == CH_RED && seq_idx == IDX_W'($past(seq_idx) + 1'b1)));

  // R4: index load wins and restarts at red
  assert_index_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> (seq_ch == CH_RED && seq_idx == $past(idx_value)));

  // R5: a masked write still moves the sequence on
  assert_masked_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go && seq_ch == CH_RED) |=> seq_ch == CH_GREEN);

endmodule

// File: rtl/gamma_lut_chan_ram.sv
module gamma_lut_chan_ram #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wbank,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic              rbank,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];

  always_ff @(posedge clk) begin
    if (we && !wbank) bank_a[waddr] <= wdata;
    if (we &&  wbank) bank_b[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= rbank ? bank_b[raddr] : bank_a[raddr];
  end

endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
  import gamma_lut_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_idx_load,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_data_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bank,
  input  logic [2:0]        wr_mask,
  input  logic [1:0]        lut_mode,
  input  logic              frame_start,
  output logic [2:0]        lut_status,
  input  logic              pix_in_valid,
  output logic              pix_in_ready,
  input  logic [IN_W-1:0]   pix_in_r,
  input  logic [IN_W-1:0]   pix_in_g,
  input  logic [IN_W-1:0]   pix_in_b,
  output logic              pix_out_valid,
  input  logic              pix_out_ready,
  output logic [DATA_W-1:0] pix_out_r,
  output logic [DATA_W-1:0] pix_out_g,
  output logic [DATA_W-1:0] pix_out_b
);

  localparam int PAD_W = DATA_W - IDX_W;

  // live lookup mode, retimed to frame boundaries
  logic [1:0] live_mode, next_mode;
  assign next_mode = frame_start ? lut_mode : live_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) live_mode <= 2'd0;
    else        live_mode <= next_mode;
  end

  assign lut_status = status_code(live_mode);

  // host sequential write port
  logic [2:0]       chan_we;
  logic [IDX_W-1:0] cur_idx;

  gamma_lut_writer #(.IDX_W(IDX_W)) u_writer (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_load   (wr_idx_load),
    .idx_value  (wr_idx),
    .data_valid (wr_data_valid),
    .mask       (wr_mask),
    .chan_we    (chan_we),
    .cur_idx    (cur_idx)
  );

  // two-stage pipeline with a global stall
  logic             adv;
  logic             s1_valid, s2_valid;
  logic [1:0]       s1_mode;
  logic             s2_bypass;
  logic [IDX_W-1:0] in_idx  [NUM_CH];
  logic [IDX_W-1:0] s1_idx  [NUM_CH];
  logic [IDX_W-1:0] s2_idx  [NUM_CH];
  logic [DATA_W-1:0] rd_val [NUM_CH];
  logic [DATA_W-1:0] out_val[NUM_CH];

  assign adv          = !s2_valid || pix_out_ready;
  assign pix_in_ready = adv;

  assign in_idx[0] = pix_in_r[IN_W-1 -: IDX_W];
  assign in_idx[1] = pix_in_g[IN_W-1 -: IDX_W];
  assign in_idx[2] = pix_in_b[IN_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s2_valid  <= 1'b0;
      s1_mode   <= 2'd0;
      s2_bypass <= 1'b1;
    end else if (adv) begin
      s1_valid  <= pix_in_valid;
      s1_mode   <= next_mode;
      s2_valid  <= s1_valid;
      s2_bypass <= !mode_uses_table(s1_mode);
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (adv) begin
        s1_idx[c] <= in_idx[c];
        s2_idx[c] <= s1_idx[c];
      end
    end

    gamma_lut_chan_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .we    (chan_we[c]),
      .wbank (wr_bank),
      .waddr (cur_idx),
      .wdata (wr_data),
      .re    (adv),
      .rbank (s1_mode == MODE_BANK_B),
      .raddr (s1_idx[c]),
      .rdata (rd_val[c])
    );

    assign out_val[c] = s2_bypass ? {s2_idx[c], {PAD_W{1'b0}}} : rd_val[c];
  end

  assign pix_out_valid = s2_valid;
  assign pix_out_r     = out_val[0];
  assign pix_out_g     = out_val[1];
  assign pix_out_b     = out_val[2];

  // R2: status moves only on a frame boundary
  assert_status_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(lut_status));

  // R2: only the three defined codes appear
  assert_status_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_status == STAT_NONE || lut_status == STAT_A || lut_status == STAT_B));

  // R8: bypass output carries zero low bits
  assert_bypass_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_valid && s2_bypass) |-> (pix_out_r[PAD_W-1:0] == '0 &&
      pix_out_g[PAD_W-1:0] == '0 && pix_out_b[PAD_W-1:0] == '0));

  // R11: accepted pixel reaches the output two stages later
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_in_valid && pix_in_ready) ##1 pix_in_ready |=> pix_out_valid);

  // R12: stalled output holds still
  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_valid && !pix_out_ready) |=> (pix_out_valid && $stable(pix_out_r) &&
      $stable(pix_out_g) && $stable(pix_out_b)));

endmodule

// File: tb/gamma_lut_top_test.sv
`timescale 1ns/1ps
module gamma_lut_top_test;

  localparam int IN_W = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_idx_load = 0;
  logic [7:0]  wr_idx = 0;
  logic        wr_data_valid = 0;
  logic [11:0] wr_data = 0;
  logic        wr_bank = 0;
  logic [2:0]  wr_mask = 3'b111;
  logic [1:0]  lut_mode = 0;
  logic        frame_start = 0;
  logic [2:0]  lut_status;
  logic        pix_in_valid = 0;
  logic        pix_in_ready;
  logic [IN_W-1:0] pix_in_r = 0, pix_in_g = 0, pix_in_b = 0;
  logic        pix_out_valid;
  logic        pix_out_ready = 1;
  logic [11:0] pix_out_r, pix_out_g, pix_out_b;

  always #5 clk = ~clk;

  gamma_lut_top #(.IN_W(IN_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .wr_idx_load(wr_idx_load), .wr_idx(wr_idx),
    .wr_data_valid(wr_data_valid), .wr_data(wr_data),
    .wr_bank(wr_bank), .wr_mask(wr_mask),
    .lut_mode(lut_mode), .frame_start(frame_start), .lut_status(lut_status),
    .pix_in_valid(pix_in_valid), .pix_in_ready(pix_in_ready),
    .pix_in_r(pix_in_r), .pix_in_g(pix_in_g), .pix_in_b(pix_in_b),
    .pix_out_valid(pix_out_valid), .pix_out_ready(pix_out_ready),
    .pix_out_r(pix_out_r), .pix_out_g(pix_out_g), .pix_out_b(pix_out_b)
  );

  int total = 0;
  int failed = 0;

  // bench model of both banks, built from the write-port rules
  logic [11:0] model [2][3][256];
  int m_idx = 0;
  int m_ch = 0;
  logic [1:0] act_mode = 0;

  // vectors: {mode[31:30], r[29:20], g[19:10], b[9:0]}
  localparam logic [31:0] VEC [8] = '{
    {2'd2, 10'd0,    10'd1023, 10'd515},
    {2'd2, 10'd7,    10'd4,    10'd1000},
    {2'd3, 10'd0,    10'd1023, 10'd515},
    {2'd3, 10'd400,  10'd401,  10'd403},
    {2'd0, 10'd1023, 10'd2,    10'd257},
    {2'd1, 10'd12,   10'd600,  10'd999},
    {2'd3, 10'd1020, 10'd3,    10'd128},
    {2'd2, 10'd255,  10'd256,  10'd511}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_val(input logic [1:0] m, input int c, input logic [IN_W-1:0] v);
    logic [7:0] i;
    i = v[IN_W-1 -: 8];
    if (m == 2'd2) return model[0][c][i];
    if (m == 2'd3) return model[1][c][i];
    return {i, 4'b0000};
  endfunction

  task automatic set_index(input int i);
    @(negedge clk);
    wr_idx_load = 1; wr_idx = 8'(i);
    m_idx = i; m_ch = 0;
    @(negedge clk);
    wr_idx_load = 0;
  endtask

  task automatic put(input logic [11:0] d);
    @(negedge clk);
    wr_data_valid = 1; wr_data = d;
    if (wr_mask[m_ch]) model[wr_bank][m_ch][m_idx] = d;
    if (m_ch == 2) begin m_ch = 0; m_idx = (m_idx + 1) % 256; end
    else m_ch++;
    @(negedge clk);
    wr_data_valid = 0;
  endtask

  task automatic send(input string req, input logic [1:0] m, input logic fs,
                      input logic [IN_W-1:0] r, input logic [IN_W-1:0] g,
                      input logic [IN_W-1:0] b);
    @(negedge clk);
    lut_mode = m; frame_start = fs; pix_out_ready = 1;
    pix_in_valid = 1; pix_in_r = r; pix_in_g = g; pix_in_b = b;
    if (fs) act_mode = m;
    @(posedge clk);
    @(negedge clk);
    frame_start = 0; pix_in_valid = 0;
    check("R11 first cycle", {31'd0, pix_out_valid}, 0);
    @(negedge clk);
    check("R11 valid", {31'd0, pix_out_valid}, 1);
    check({req, " red"},   {20'd0, pix_out_r}, {20'd0, exp_val(act_mode, 0, r)});
    check({req, " green"}, {20'd0, pix_out_g}, {20'd0, exp_val(act_mode, 1, g)});
    check({req, " blue"},  {20'd0, pix_out_b}, {20'd0, exp_val(act_mode, 2, b)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {31'd0, pix_out_valid}, 0);
    check("R1 status", {29'd0, lut_status}, 0);
    check("R1 in_ready", {31'd0, pix_in_ready}, 1);
    rst_n = 1;
    // R1: bypass before any frame start
    send("R1 bypass", 2'd0, 1'b0, 10'd100, 10'd200, 10'd300);

    // R6: load bank A then bank B with distinct contents
    for (int bk = 0; bk < 2; bk++) begin
      wr_bank = bk[0];
      set_index(0);
      for (int i = 0; i < 256; i++)
        for (int c = 0; c < 3; c++)
          put(bk == 0 ? 12'(i * 16 + c) : 12'((255 - i) * 16 + 8 + c));
    end

    // R10: mode request without frame start stays in bypass
    send("R10 no strobe", 2'd2, 1'b0, 10'd40, 10'd80, 10'd120);
    check("R2 status unchanged", {29'd0, lut_status}, 0);

    // vector walk, each with a frame strobe (R7, R8, R9, R10, R6)
    for (int v = 0; v < 8; v++) begin
      logic [1:0] m;
      m = VEC[v][31:30];
      send((m == 2'd2 || m == 2'd3) ? "R7 R9 R6 lookup" : "R8 R9 bypass",
           m, 1'b1, VEC[v][29:20], VEC[v][19:10], VEC[v][9:0]);
      check("R2 status", {29'd0, lut_status},
            m == 2'd2 ? 32'd1 : (m == 2'd3 ? 32'd2 : 32'd0));
    end

    // R10: request B without strobe keeps A live
    send("R10 held A", 2'd3, 1'b0, 10'd21, 10'd22, 10'd23);
    check("R2 status held", {29'd0, lut_status}, 1);

    // R5: mask only green at index 5, then a full triplet lands on 6
    wr_bank = 0;
    set_index(5);
    wr_mask = 3'b010;
    put(12'd3001); put(12'd3002); put(12'd3003);
    wr_mask = 3'b111;
    put(12'd3101); put(12'd3102); put(12'd3103);
    send("R5 mask", 2'd2, 1'b1, 10'd21, 10'd22, 10'd23);
    send("R5 advance", 2'd2, 1'b0, 10'd25, 10'd26, 10'd27);
    check("R5 red kept", {20'd0, model[0][0][5]}, 32'd80);

    // R4: reload index mid-triplet overwrites red again
    set_index(20);
    put(12'd1111);
    set_index(20);
    put(12'd2222);
    send("R4 reload", 2'd2, 1'b0, 10'd80, 10'd80, 10'd80);

    // R4: index load coinciding with a data write drops the data
    @(negedge clk);
    wr_idx_load = 1; wr_idx = 8'd9; wr_data_valid = 1; wr_data = 12'd4000;
    m_idx = 9; m_ch = 0;
    @(negedge clk);
    wr_idx_load = 0; wr_data_valid = 0;
    put(12'd1234);
    send("R4 collide", 2'd2, 1'b0, 10'd36, 10'd36, 10'd36);
    check("R4 green untouched", {20'd0, pix_out_g}, 32'd145);

    // R3: wrap from 255 to 0 in bank B
    wr_bank = 1;
    set_index(255);
    put(12'd501); put(12'd502); put(12'd503);
    put(12'd504);
    send("R3 wrap end", 2'd3, 1'b1, 10'd1023, 10'd1022, 10'd1021);
    send("R3 wrap start", 2'd3, 1'b0, 10'd0, 10'd1, 10'd2);
    check("R3 wrapped red", {20'd0, pix_out_r}, 32'd504);
    check("R2 status B", {29'd0, lut_status}, 2);

    // R12: stall with three pixels in flight (bank B live)
    @(negedge clk);
    pix_out_ready = 0; pix_in_valid = 1;
    pix_in_r = 10'd40; pix_in_g = 10'd40; pix_in_b = 10'd40;
    @(negedge clk);
    pix_in_r = 10'd80; pix_in_g = 10'd80; pix_in_b = 10'd80;
    @(negedge clk);
    check("R12 in_ready low", {31'd0, pix_in_ready}, 0);
    check("R12 first held", {20'd0, pix_out_r}, {20'd0, exp_val(2'd3, 0, 10'd40)});
    pix_in_r = 10'd120; pix_in_g = 10'd120; pix_in_b = 10'd120;
    @(negedge clk);
    check("R12 still held", {20'd0, pix_out_g}, {20'd0, exp_val(2'd3, 1, 10'd40)});
    check("R12 valid held", {31'd0, pix_out_valid}, 1);
    pix_out_ready = 1;
    @(negedge clk);
    pix_in_valid = 0;
    check("R12 second", {20'd0, pix_out_r}, {20'd0, exp_val(2'd3, 0, 10'd80)});
    @(negedge clk);
    check("R12 third", {20'd0, pix_out_b}, {20'd0, exp_val(2'd3, 2, 10'd120)});
    @(negedge clk);
    check("R12 drained", {31'd0, pix_out_valid}, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule